// File: doc/BRIEF.md
# External Clock Select and Divider Control

This block decides when the clock source should switch to an external bypass clock. It also derives two slower clocks from the io clock. Two request paths feed the decision. The first is a software path: a select field and a high-speed field, enabled only while a life-cycle debug-enable input is On. The second is a life-cycle bypass request input that needs no software involvement. Each path drives its own bypass request output toward the analog clock source.

The block produces the io/2 and io/4 clocks with counter-based dividers clocked by the io clock. Whenever an external clock is selected and scan mode is not true, the step-down condition holds, and both ratios double. The life-cycle path always causes step-down. The software path causes it only when its high-speed field is true. A divider takes up a new ratio only at the end of a full divided period, so it never emits a runt pulse. A jitter-enable output mirrors its register field.

Every decision is registered once. The dividers then adopt the registered step-down flag at their next period boundary.

Top module: `ecs_top`

## Requirements
- R1: `all_byp_req_o` is 4'h6 in the cycle after `sw_sel_i` == 4'h6 and `dbg_en_i` == 4'b1010 both hold. Otherwise it is 4'h9 in the following cycle.
- R2: `io_byp_req_o` is 4'b1010 in the cycle after `lc_byp_i` == 4'b1010. Otherwise it is 4'b0101. Each transition of the input is followed one cycle later by the matching transition of the output.
- R3: The life-cycle request steps the dividers down even when the software select field is false and debug enable is off.
- R4: Step-down through the software path needs the path to be active (R1) and `sw_hispeed_i` == 4'h6. When the path is active and the high-speed field is any other value, the dividers stay at their nominal ratios.
- R5: While `scan_i` == 4'h6, step-down is suppressed on both paths.
- R6: `jitter_en_o` equals the `jitter_field_i` value sampled one cycle earlier, on all four bits.
- R7: Any 4-bit value other than the defined true/On code counts as off, on every encoded input.
- R8: `clk_div_o[0]` has a period of 2 io cycles and `clk_div_o[1]` a period of 4, each with 50% duty. Under step-down both periods double, and the duty stays at 50%.
- R9: A divider changes ratio only at the end of a complete divided period. Every period is either the nominal or the doubled length, with no short pulses.
- R10: With `rst_i` high at a clock edge, `all_byp_req_o` becomes 4'h9, `io_byp_req_o` 4'b0101, `jitter_en_o` 4'h9 and `clk_div_o` 0. Each divider starts a fresh nominal period on the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | io clock |
| rst_i | input | 1 | synchronous active-high reset |
| sw_sel_i | input | 4 | software external-select field (true = 4'h6) |
| sw_hispeed_i | input | 4 | software high-speed field (true = 4'h6) |
| dbg_en_i | input | 4 | life-cycle debug enable (On = 4'b1010) |
| lc_byp_i | input | 4 | life-cycle bypass request (On = 4'b1010) |
| scan_i | input | 4 | scan mode (true = 4'h6) |
| jitter_field_i | input | 4 | jitter-enable register field |
| all_byp_req_o | output | 4 | all-clock bypass request (4'h6 / 4'h9) |
| io_byp_req_o | output | 4 | io bypass request (4'b1010 / 4'b0101) |
| jitter_en_o | output | 4 | registered copy of the jitter field |
| clk_div_o | output | 2 | bit 0: io/2 clock, bit 1: io/4 clock |

## Verification
The bench targets the gating of the software path by debug enable. A design that skips this gate would raise the all-clock request, or step down, with debug off. The bench also drives near-miss codes such as 4'h7 and 4'b1011, which a single-bit decode would take as true. It confirms that scan mode holds the nominal ratios even while the life-cycle request is On. Finally, it toggles step-down at random phases of the divided clocks. A divider that switched ratio mid-period would show a short high or low phase, and the cycle-accurate model would flag the mismatch.

// File: rtl/ecs_pkg.sv
package ecs_pkg;
  localparam int ENC_W = 4;
  typedef logic [ENC_W-1:0] enc_t;

  // Redundant encodings: only the exact code counts as asserted.
  localparam enc_t MB_TRUE  = 4'h6;
  localparam enc_t MB_FALSE = 4'h9;
  localparam enc_t LC_ON    = 4'b1010;
  localparam enc_t LC_OFF   = 4'b0101;

  function automatic logic mb_is_true(enc_t v);
    return v == MB_TRUE;
  endfunction

  function automatic logic lc_is_on(enc_t v);
    return v == LC_ON;
  endfunction

  function automatic enc_t mb_from_bit(logic b);
    return b ? MB_TRUE : MB_FALSE;
  endfunction

  function automatic enc_t lc_from_bit(logic b);
    return b ? LC_ON : LC_OFF;
  endfunction
endpackage

// File: rtl/ecs_decide.sv
module ecs_decide
  import ecs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  enc_t sw_sel_i,
  input  enc_t sw_hispeed_i,
  input  enc_t dbg_en_i,
  input  enc_t lc_byp_i,
  input  enc_t scan_i,
  input  enc_t jitter_field_i,
  output enc_t all_req_o,
  output enc_t io_req_o,
  output enc_t jitter_o,
  output logic step_o
);
  logic sw_act, lc_act, ext_sel, scan_on, step_d;

  always_comb begin
    sw_act  = mb_is_true(sw_sel_i) && lc_is_on(dbg_en_i);
    lc_act  = lc_is_on(lc_byp_i);
    ext_sel = sw_act || lc_act;
    scan_on = mb_is_true(scan_i);
    // Life-cycle path always steps down; software path only at high speed.
    step_d  = ext_sel && !scan_on && (lc_act || (sw_act && mb_is_true(sw_hispeed_i)));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      all_req_o <= MB_FALSE;
      io_req_o  <= LC_OFF;
      jitter_o  <= MB_FALSE;
      step_o    <= 1'b0;
    end else begin
      all_req_o <= mb_from_bit(sw_act);
      io_req_o  <= lc_from_bit(lc_act);
      jitter_o  <= jitter_field_i;
      step_o    <= step_d;
    end
  end

  AST_ALL_REQ_NEEDS_DBG: assert property (@(posedge clk_i) disable iff (rst_i)
    !lc_is_on(dbg_en_i) |=> (all_req_o == MB_FALSE)); // R1
  AST_IO_REQ_FOLLOWS_LC: assert property (@(posedge clk_i) disable iff (rst_i)
    lc_is_on(lc_byp_i) |=> (io_req_o == LC_ON)); // R2
  AST_SCAN_BLOCKS_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    mb_is_true(scan_i) |=> !step_o); // R5
  AST_JITTER_MIRROR: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (jitter_o == $past(jitter_field_i))); // R6
endmodule

// File: rtl/ecs_div.sv
module ecs_div #(
  parameter int RATIO = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic step_i,
  output logic clk_o
);
  localparam int SLOW = 2 * RATIO;
  localparam int CW   = $clog2(SLOW);

  logic [CW-1:0] cnt_q, cnt_d, last_cnt, half_d;
  logic          slow_q, slow_d, wrap, out_d;

  always_comb begin
    last_cnt = slow_q ? CW'(SLOW - 1) : CW'(RATIO - 1);
    wrap     = (cnt_q == last_cnt);
    if (wrap) begin
      cnt_d  = '0;
      slow_d = step_i;       // ratio is only adopted at a period boundary
    end else begin
      cnt_d  = cnt_q + 1'b1;
      slow_d = slow_q;
    end
    half_d = slow_d ? CW'(SLOW / 2) : CW'(RATIO / 2);
    out_d  = (cnt_d < half_d);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= CW'(RATIO - 1);
      slow_q <= 1'b0;
      clk_o  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      slow_q <= slow_d;
      clk_o  <= out_d;
    end
  end

  AST_DIV_RATIO_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (rst_i)
    (slow_q != $past(slow_q)) |-> $past(wrap)); // R9
  AST_DIV_RISE_AT_START: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(clk_o) |-> (cnt_q == '0)); // R8
endmodule

// File: rtl/ecs_top.sv
module ecs_top
  import ecs_pkg::*;
#(
  parameter int NUM_DIV    = 2,
  parameter int BASE_RATIO = 2
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [3:0]         sw_sel_i,
  input  logic [3:0]         sw_hispeed_i,
  input  logic [3:0]         dbg_en_i,
  input  logic [3:0]         lc_byp_i,
  input  logic [3:0]         scan_i,
  input  logic [3:0]         jitter_field_i,
  output logic [3:0]         all_byp_req_o,
  output logic [3:0]         io_byp_req_o,
  output logic [3:0]         jitter_en_o,
  output logic [NUM_DIV-1:0] clk_div_o
);
  logic step;

  ecs_decide i_decide (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .sw_sel_i       (sw_sel_i),
    .sw_hispeed_i   (sw_hispeed_i),
    .dbg_en_i       (dbg_en_i),
    .lc_byp_i       (lc_byp_i),
    .scan_i         (scan_i),
    .jitter_field_i (jitter_field_i),
    .all_req_o      (all_byp_req_o),
    .io_req_o       (io_byp_req_o),
    .jitter_o       (jitter_en_o),
    .step_o         (step)
  );

  // Divider i runs at BASE_RATIO * 2^i nominally, doubled under step-down.
  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    ecs_div #(.RATIO(BASE_RATIO << i)) i_div (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .step_i (step),
      .clk_o  (clk_div_o[i])
    );
  end
endmodule

// File: tb/test_ecs_top.sv
module test_ecs_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] sel = 4'h9, hs = 4'h9, dbg = 4'b0101, lcb = 4'b0101, scan = 4'h9, jit = 4'h9;
  logic [3:0] all_o, io_o, jit_o;
  logic [1:0] div_o;

  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "R10";

  // reference state
  int m_all, m_io, m_jit;
  bit m_step;
  int pos[2], per[2];
  bit mout[2];
  bit prev[2];
  int rises[2];

  always #2 clk = ~clk;

  ecs_top i_ecs_top (
    .clk_i(clk), .rst_i(rst), .sw_sel_i(sel), .sw_hispeed_i(hs), .dbg_en_i(dbg),
    .lc_byp_i(lcb), .scan_i(scan), .jitter_field_i(jit),
    .all_byp_req_o(all_o), .io_byp_req_o(io_o), .jitter_en_o(jit_o), .clk_div_o(div_o));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (rst) begin
      m_all = 9; m_io = 5; m_jit = 9; m_step = 0;
      for (int i = 0; i < 2; i++) begin
        pos[i] = (2 << i) - 1; per[i] = 2 << i; mout[i] = 0;
      end
    end else begin
      bit sw, lc;
      for (int i = 0; i < 2; i++) begin
        if (pos[i] == per[i] - 1) begin
          pos[i] = 0;
          per[i] = m_step ? (4 << i) : (2 << i);
        end else pos[i]++;
        mout[i] = pos[i] < per[i] / 2;
      end
      sw = (sel == 4'h6) && (dbg == 4'b1010);
      lc = (lcb == 4'b1010);
      m_all = sw ? 6 : 9;
      m_io = lc ? 10 : 5;
      m_jit = jit;
      m_step = (sw || lc) && (scan != 4'h6) && (lc || (sw && hs == 4'h6));
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    model_edge();
    @(negedge clk);
    chk({phase, "/R1"}, "all_byp_req", all_o, m_all);
    chk({phase, "/R2"}, "io_byp_req", io_o, m_io);
    chk({phase, "/R6"}, "jitter_en", jit_o, m_jit);
    chk({phase, "/R9"}, "clk_div0", div_o[0], mout[0]);
    chk({phase, "/R9"}, "clk_div1", div_o[1], mout[1]);
    for (int i = 0; i < 2; i++) begin
      if (div_o[i] && !prev[i]) rises[i]++;
      prev[i] = div_o[i];
    end
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  // Settle, then count rising edges over 16 cycles; period P gives 16/P rises.
  task automatic measure(string req, int p0, int p1);
    run(20);
    rises[0] = 0; rises[1] = 0;
    run(16);
    chk(req, "div0 rises in 16", rises[0], 16 / p0);
    chk(req, "div1 rises in 16", rises[1], 16 / p1);
  endtask

  task automatic set_all(logic [3:0] s, logic [3:0] h, logic [3:0] d,
                         logic [3:0] l, logic [3:0] sc);
    sel = s; hs = h; dbg = d; lcb = l; scan = sc;
  endtask

  initial begin
    #600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    prev[0] = 0; prev[1] = 0;
    @(negedge clk);
    run(3);
    // R10: reset state
    chk("R10", "all reset", all_o, 4'h9);
    chk("R10", "io reset", io_o, 4'b0101);
    chk("R10", "jit reset", jit_o, 4'h9);
    chk("R10", "div reset", div_o, 0);
    rst = 0;
    phase = "R8";
    measure("R8 nominal", 2, 4);

    phase = "R1";
    set_all(4'h6, 4'h9, 4'b0101, 4'b0101, 4'h9); run(2);
    chk("R1", "dbg off blocks", all_o, 4'h9);
    dbg = 4'b1010; run(2);
    chk("R1", "sw active", all_o, 4'h6);
    measure("R4 no hispeed", 2, 4);

    phase = "R4";
    hs = 4'h6;
    measure("R4 sw step", 4, 8);
    dbg = 4'b0101;
    measure("R4 dbg off", 2, 4);

    phase = "R7";
    set_all(4'h7, 4'h6, 4'b1010, 4'b1011, 4'h9); run(2);
    chk("R7", "near-miss sel", all_o, 4'h9);
    chk("R7", "near-miss lc", io_o, 4'b0101);
    measure("R7 no step", 2, 4);

    phase = "R3";
    set_all(4'h9, 4'h9, 4'b0101, 4'b1010, 4'h9); run(2);
    chk("R2", "lc on", io_o, 4'b1010);
    chk("R3", "all stays off", all_o, 4'h9);
    measure("R3 lc step", 4, 8);

    phase = "R5";
    scan = 4'h6;
    measure("R5 scan suppress", 2, 4);
    set_all(4'h6, 4'h6, 4'b1010, 4'b0101, 4'h6);
    measure("R5 scan sw", 2, 4);

    phase = "R6";
    for (int k = 0; k < 40; k++) begin jit = 4'($urandom); cyc(); end

    phase = "R9";
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom % 8;
      if (r == 0) sel = ($urandom % 2) ? 4'h6 : 4'($urandom);
      if (r == 1) hs = ($urandom % 2) ? 4'h6 : 4'($urandom);
      if (r == 2) dbg = ($urandom % 2) ? 4'b1010 : 4'($urandom);
      if (r == 3) lcb = ($urandom % 2) ? 4'b1010 : 4'($urandom);
      if (r == 4) scan = ($urandom % 3 == 0) ? 4'h6 : 4'($urandom);
      if (r == 5) jit = 4'($urandom);
      if (k % 500 == 499) rst = 1; else rst = 0;
      cyc();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule